// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel

This block is one DMA channel whose working state sits in memory, not in local registers. A three-word descriptor holds the remaining byte count, the source pointer and the destination pointer. Software writes the descriptor, picks the address stepping for each side and the pacing mode, then arms the channel. When a transfer request arrives on an armed channel, the engine asks for the shared bus. After the grant it fetches the descriptor and moves bytes one at a time. It then writes the changed descriptor fields back and hands the bus over again.

There are two pacing modes. In continuous mode the requester paces each transfer: the engine continues only while the request is held and bytes remain. In burst mode one accepted request empties the whole count. During every data phase the engine drives an acknowledge strobe. The transfer that brings the count to zero also drives an end strobe. When the count is exhausted the channel disarms itself. It can also leave a sticky interrupt flag for the CPU.

Top module: `dma_desc_chan`

## Requirements
- R1: While the channel is disarmed, `busReq` stays low whatever `dreq` does. A one-cycle pulse on `armSet` arms it (`armed` goes high).
- R2: An armed channel that samples `dreq` high raises `busReq`. It makes no memory access in a cycle where `busGnt` is low. `busReq` stays high until the service ends.
- R3: After the grant, the descriptor is read from three consecutive word addresses in this order: `descBase` (count), `descBase+1` (source), `descBase+2` (destination).
- R4: Each transfer decrements the count once. It reads the word at the source pointer and writes its low 8 bits, zero-extended to the full word, to the destination pointer.
- R5: `xferAck` is high for exactly three cycles per transfer. `xferEnd` is high in exactly those three cycles of the transfer whose decremented count is zero, and never without `xferAck`.
- R6: In continuous mode (`burstMode`=0), another transfer starts only if the count is nonzero and `dreq` is high in the last cycle of the previous transfer.
- R7: In burst mode (`burstMode`=1), transfers run back to back until the count is zero, whatever `dreq` does.
- R8: Address mode field per side: 2'b00 fixed, 2'b01 step +1, 2'b10 step -1, 2'b11 fixed. A stepping pointer changes by one after each transfer.
- R9: At the end of a sequence the count is written to `descBase`. Then the source pointer is written to `descBase+1` only if its mode steps. Then the destination pointer is written to `descBase+2` only if its mode steps.
- R10: A service with n transfers and k stepping pointers keeps `busReq` high for exactly 6+5n+k rising edges at which `busGnt` is high.
- R11: A service that leaves the count at zero clears `armed` and, if `irqEn` is 1, sets `irq`. `irq` holds until an `irqClr` pulse. A service that ends with count nonzero leaves the channel armed, and a later request resumes from the written-back descriptor.
- R12: A descriptor fetched with a zero count performs no transfer: it goes straight to write-back and finishes as in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| armSet | input | 1 | Pulse that arms the channel |
| irqEn | input | 1 | Allow the end-of-count interrupt |
| irqClr | input | 1 | Pulse that clears the interrupt flag |
| burstMode | input | 1 | 1 = run to completion, 0 = request paced |
| srcMode | input | 2 | Source pointer stepping |
| dstMode | input | 2 | Destination pointer stepping |
| descBase | input | AW | Word address of the descriptor |
| dreq | input | 1 | Transfer request |
| busReq | output | 1 | Bus ownership request |
| busGnt | input | 1 | Bus ownership grant |
| memAddr | output | AW | Memory word address |
| memRe | output | 1 | Memory read strobe (data returned the same cycle) |
| memWe | output | 1 | Memory write strobe |
| memWdata | output | DW | Memory write data |
| memRdata | input | DW | Memory read data |
| xferAck | output | 1 | Data-phase acknowledge |
| xferEnd | output | 1 | Data phase of the final transfer |
| armed | output | 1 | Channel enable state |
| irq | output | 1 | Sticky end-of-count interrupt |

## Verification
The bench targets these corners:
- Withdrawing `dreq` exactly at the end of a continuous transfer. A design that samples the request too early or too late moves one byte too many or too few.
- Dropping `dreq` after the first transfer in burst mode. A design that re-samples the request stops short.
- A zero count in the descriptor. A design that decrements it anyway wraps to 65535 and runs away.
- The mode value 11, and the mix of fixed and stepping pointers. A design that writes back an unchanged pointer, or forgets a stepped one, breaks both the write sequence and the 6+5n+k cycle count.
- A continuous service that ends early, followed by a second request. A design that lost its write-back resumes from stale pointers.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_REQ, ST_DSC0, ST_DSC1, ST_DSC2,
    ST_X0, ST_X1, ST_X2, ST_X3, ST_X4,
    ST_WBC, ST_WBS, ST_WBD, ST_REL
  } chanStateT;

  typedef enum logic [2:0] {
    AS_BASE0, AS_BASE1, AS_BASE2, AS_SRC, AS_DST
  } addrSelT;

  typedef enum logic [1:0] {
    WD_CNT, WD_SRC, WD_DST, WD_BYTE
  } wdSelT;

  typedef struct packed {
    logic    latchBase;
    logic    ldCnt;
    logic    ldSrc;
    logic    ldDst;
    logic    decCnt;
    logic    capByte;
    logic    stepPtr;
    addrSelT addrSel;
    wdSelT   wdSel;
  } dpCtrlT;

  localparam logic [1:0] MODE_FIXED = 2'b00;
  localparam logic [1:0] MODE_INC   = 2'b01;
  localparam logic [1:0] MODE_DEC   = 2'b10;

  function automatic logic modeSteps(input logic [1:0] m);
    return (m == MODE_INC) || (m == MODE_DEC);
  endfunction

endpackage

// File: rtl/dma_desc_dp.sv
module dma_desc_dp
  import dma_desc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtrlT        ctl,
  input  logic [AW-1:0] descBase,
  input  logic [1:0]    srcMode,
  input  logic [1:0]    dstMode,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          cntZero
);

  localparam logic [AW-1:0] ONE_A = AW'(1);
  localparam logic [AW-1:0] TWO_A = AW'(2);

  logic [AW-1:0] baseQ, srcQ, dstQ;
  logic [DW-1:0] cntQ;
  logic [BW-1:0] byteQ;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] a, input logic [1:0] m);
    case (m)
      MODE_INC: return a + ONE_A;
      MODE_DEC: return a - ONE_A;
      default:  return a;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      srcQ  <= '0;
      dstQ  <= '0;
      cntQ  <= '0;
      byteQ <= '0;
    end else begin
      if (ctl.latchBase) baseQ <= descBase;
      if (ctl.ldCnt)       cntQ <= memRdata;
      else if (ctl.decCnt) cntQ <= cntQ - DW'(1);
      if (ctl.ldSrc)        srcQ <= memRdata[AW-1:0];
      else if (ctl.stepPtr) srcQ <= nextPtr(srcQ, srcMode);
      if (ctl.ldDst)        dstQ <= memRdata[AW-1:0];
      else if (ctl.stepPtr) dstQ <= nextPtr(dstQ, dstMode);
      if (ctl.capByte) byteQ <= memRdata[BW-1:0];
    end
  end

  always_comb begin
    case (ctl.addrSel)
      AS_BASE0: memAddr = baseQ;
      AS_BASE1: memAddr = baseQ + ONE_A;
      AS_BASE2: memAddr = baseQ + TWO_A;
      AS_SRC:   memAddr = srcQ;
      AS_DST:   memAddr = dstQ;
      default:  memAddr = baseQ;
    endcase
    case (ctl.wdSel)
      WD_CNT:  memWdata = cntQ;
      WD_SRC:  memWdata = DW'(srcQ);
      WD_DST:  memWdata = DW'(dstQ);
      default: memWdata = DW'(byteQ);
    endcase
  end

  assign cntZero = (cntQ == '0);

  // R4: a decrement never meets an empty count
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.decCnt |-> (cntQ != '0));

  // R8: a fixed source pointer does not move on a step strobe
  p_fixed_src_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepPtr && !modeSteps(srcMode)) |=> $stable(srcQ));

endmodule

// File: rtl/dma_desc_ctrl.sv
module dma_desc_ctrl
  import dma_desc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       armSet,
  input  logic       irqEn,
  input  logic       irqClr,
  input  logic       burstMode,
  input  logic [1:0] srcMode,
  input  logic [1:0] dstMode,
  input  logic       dreq,
  input  logic       busGnt,
  input  logic       cntZero,
  output dpCtrlT     ctl,
  output logic       busReq,
  output logic       memRe,
  output logic       memWe,
  output logic       xferAck,
  output logic       xferEnd,
  output logic       armed,
  output logic       irq
);

  chanStateT stateQ, stateD;
  logic srcSteps, dstSteps;

  assign srcSteps = modeSteps(srcMode);
  assign dstSteps = modeSteps(dstMode);

  always_comb begin
    stateD  = stateQ;
    ctl     = '0;
    ctl.addrSel = AS_BASE0;
    ctl.wdSel   = WD_CNT;
    memRe   = 1'b0;
    memWe   = 1'b0;
    xferAck = 1'b0;
    xferEnd = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        ctl.latchBase = 1'b1;
        if (armed && dreq) stateD = ST_REQ;
      end
      ST_REQ: if (busGnt) stateD = ST_DSC0;
      ST_DSC0: begin
        memRe = 1'b1; ctl.ldCnt = 1'b1; ctl.addrSel = AS_BASE0;
        stateD = ST_DSC1;
      end
      ST_DSC1: begin
        memRe = 1'b1; ctl.ldSrc = 1'b1; ctl.addrSel = AS_BASE1;
        stateD = ST_DSC2;
      end
      ST_DSC2: begin
        memRe = 1'b1; ctl.ldDst = 1'b1; ctl.addrSel = AS_BASE2;
        stateD = cntZero ? ST_WBC : ST_X0;
      end
      ST_X0: begin
        ctl.decCnt = 1'b1;
        stateD = ST_X1;
      end
      ST_X1: begin
        memRe = 1'b1; ctl.capByte = 1'b1; ctl.addrSel = AS_SRC;
        xferAck = 1'b1; xferEnd = cntZero;
        stateD = ST_X2;
      end
      ST_X2: begin
        xferAck = 1'b1; xferEnd = cntZero;
        stateD = ST_X3;
      end
      ST_X3: begin
        memWe = 1'b1; ctl.addrSel = AS_DST; ctl.wdSel = WD_BYTE;
        xferAck = 1'b1; xferEnd = cntZero;
        stateD = ST_X4;
      end
      ST_X4: begin
        ctl.stepPtr = 1'b1;
        stateD = (cntZero || (!burstMode && !dreq)) ? ST_WBC : ST_X0;
      end
      ST_WBC: begin
        memWe = 1'b1; ctl.addrSel = AS_BASE0; ctl.wdSel = WD_CNT;
        stateD = srcSteps ? ST_WBS : (dstSteps ? ST_WBD : ST_REL);
      end
      ST_WBS: begin
        memWe = 1'b1; ctl.addrSel = AS_BASE1; ctl.wdSel = WD_SRC;
        stateD = dstSteps ? ST_WBD : ST_REL;
      end
      ST_WBD: begin
        memWe = 1'b1; ctl.addrSel = AS_BASE2; ctl.wdSel = WD_DST;
        stateD = ST_REL;
      end
      ST_REL:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign busReq = (stateQ != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      armed  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (armSet) armed <= 1'b1;
      else if (stateQ == ST_REL && cntZero) armed <= 1'b0;
      if (stateQ == ST_REL && cntZero && irqEn) irq <= 1'b1;
      else if (irqClr) irq <= 1'b0;
    end
  end

  // R1: a bus request only ever starts from an armed channel
  p_arm_before_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(armed));

  // R2: no memory traffic without the grant
  p_gnt_before_mem_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memRe || memWe) |-> busGnt);

  // R5: the end strobe only appears inside a data phase
  p_end_with_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    xferEnd |-> xferAck);

  // R11: the interrupt flag holds until cleared
  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClr) |=> irq);

endmodule

// File: rtl/dma_desc_chan.sv
module dma_desc_chan
  import dma_desc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          armSet,
  input  logic          irqEn,
  input  logic          irqClr,
  input  logic          burstMode,
  input  logic [1:0]    srcMode,
  input  logic [1:0]    dstMode,
  input  logic [AW-1:0] descBase,
  input  logic          dreq,
  output logic          busReq,
  input  logic          busGnt,
  output logic [AW-1:0] memAddr,
  output logic          memRe,
  output logic          memWe,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  output logic          xferAck,
  output logic          xferEnd,
  output logic          armed,
  output logic          irq
);

  localparam int BW = 8;

  dpCtrlT ctl;
  logic   cntZero;

  dma_desc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .armSet(armSet), .irqEn(irqEn), .irqClr(irqClr),
    .burstMode(burstMode), .srcMode(srcMode), .dstMode(dstMode),
    .dreq(dreq), .busGnt(busGnt), .cntZero(cntZero), .ctl(ctl),
    .busReq(busReq), .memRe(memRe), .memWe(memWe),
    .xferAck(xferAck), .xferEnd(xferEnd), .armed(armed), .irq(irq)
  );

  dma_desc_dp #(.AW(AW), .DW(DW), .BW(BW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .descBase(descBase),
    .srcMode(srcMode), .dstMode(dstMode), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .cntZero(cntZero)
  );

endmodule

// File: tb/tb_dma_desc_chan.sv
module tb_dma_desc_chan;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armSet = 1'b0, irqEn = 1'b0, irqClr = 1'b0, burstMode = 1'b0;
  logic [1:0] srcModeR = 2'b00, dstModeR = 2'b00;
  logic [15:0] descBase = 16'd0;
  logic dreq = 1'b0, busGnt = 1'b0;
  logic busReq, memRe, memWe, xferAck, xferEnd, armed, irq;
  logic [15:0] memAddr, memWdata, memRdata;

  logic [15:0] mem [0:1023];
  logic [15:0] expA [0:63];
  logic [15:0] expD [0:63];
  int checks = 0, errors = 0;
  int unusedSeed;

  always #4 clk = ~clk;

  dma_desc_chan dut (
    .clk(clk), .rstN(rstN), .armSet(armSet), .irqEn(irqEn), .irqClr(irqClr),
    .burstMode(burstMode), .srcMode(srcModeR), .dstMode(dstModeR),
    .descBase(descBase), .dreq(dreq), .busReq(busReq), .busGnt(busGnt),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe), .memWdata(memWdata),
    .memRdata(memRdata), .xferAck(xferAck), .xferEnd(xferEnd),
    .armed(armed), .irq(irq)
  );

  assign memRdata = mem[memAddr[9:0]];
  always @(posedge clk) if (memWe) mem[memAddr[9:0]] <= memWdata;

  function automatic logic [15:0] stepF(input logic [15:0] a, input logic [1:0] m);
    if (m == 2'b01) return a + 16'd1;
    if (m == 2'b10) return a - 16'd1;
    return a;
  endfunction

  function automatic bit stepsF(input logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulseArm();
    armSet = 1'b1; @(negedge clk); armSet = 1'b0;
  endtask

  task automatic pulseClr();
    irqClr = 1'b1; @(negedge clk); irqClr = 1'b0;
  endtask

  task automatic setDesc(input logic [15:0] base, input logic [15:0] cnt,
                         input logic [15:0] s, input logic [15:0] d);
    mem[base[9:0]] = cnt;
    mem[base[9:0] + 10'd1] = s;
    mem[base[9:0] + 10'd2] = d;
    descBase = base;
  endtask

  // One service: bench model computes writes, cycles and final flags, then it runs
  task automatic runService(input bit burst, input int kReq);
    logic [15:0] base, s, d;
    int c, n, ne, k, cyc, acks, ends, wIdx, rIdx, xfers, guard, gDelay, gWait;
    bit seenReq, prevAck, done, irqBefore, finalZero;
    string pacTag;
    base = descBase; burstMode = burst;
    c = int'(mem[base[9:0]]); s = mem[base[9:0] + 10'd1]; d = mem[base[9:0] + 10'd2];
    n = 0; ne = 0; k = 0;
    if (c != 0) begin
      int lim;
      lim = burst ? c : ((kReq < c) ? kReq : c);
      for (int i = 0; i < lim; i++) begin
        expA[ne] = d; expD[ne] = {8'h00, mem[s[9:0]][7:0]}; ne++;
        s = stepF(s, srcModeR); d = stepF(d, dstModeR); c--; n++;
      end
    end
    expA[ne] = base; expD[ne] = 16'(c); ne++;
    if (stepsF(srcModeR)) begin expA[ne] = base + 16'd1; expD[ne] = s; ne++; k++; end
    if (stepsF(dstModeR)) begin expA[ne] = base + 16'd2; expD[ne] = d; ne++; k++; end
    finalZero = (c == 0);
    irqBefore = irq;
    pacTag = burst ? "R7" : "R6";

    cyc = 0; acks = 0; ends = 0; wIdx = 0; rIdx = 0; xfers = 0; guard = 0;
    gDelay = int'($urandom % 4); gWait = 0; seenReq = 0; prevAck = 0; done = 0;
    dreq = 1'b1;
    while (!done) begin
      @(posedge clk); @(negedge clk);
      if (busReq) seenReq = 1;
      if ((memRe || memWe) && !busGnt) check(0, "R2 access without grant", 1, 0);
      if (memRe && rIdx < 3) begin
        check(memAddr == base + 16'(rIdx), "R3 descriptor read address",
              int'(memAddr), int'(base) + rIdx);
        rIdx++;
      end
      if (memWe) begin
        if (wIdx < ne) begin
          check(memAddr == expA[wIdx], "R9 write address", int'(memAddr), int'(expA[wIdx]));
          check(memWdata == expD[wIdx], "R4 write data", int'(memWdata), int'(expD[wIdx]));
        end else check(0, "R9 extra write", wIdx, ne);
        wIdx++;
      end
      if (xferAck) acks++;
      if (xferEnd) ends++;
      if (prevAck && !xferAck) begin
        xfers++;
        if (xfers >= kReq) dreq = 1'b0;
      end
      prevAck = xferAck;
      if (!busReq) begin busGnt = 1'b0; gWait = 0; end
      else if (!busGnt) begin
        if (gWait >= gDelay) busGnt = 1'b1; else gWait++;
      end
      if (busReq && busGnt) cyc++;
      if (seenReq && !busReq) done = 1;
      guard++;
      if (guard > 3000) begin check(0, "R2 service never ended", guard, 0); done = 1; end
    end
    dreq = 1'b0;
    check(cyc == 6 + 5*n + k, "R10 granted cycles", cyc, 6 + 5*n + k);
    check(acks == 3*n, "R5 ack cycles", acks, 3*n);
    check(ends == ((finalZero && n > 0) ? 3 : 0), "R5 end cycles", ends,
          (finalZero && n > 0) ? 3 : 0);
    check(xfers == n, {pacTag, " transfer count"}, xfers, n);
    check(wIdx == ne, "R9 number of writes", wIdx, ne);
    check(mem[base[9:0]] == 16'(c), "R9 count written back", int'(mem[base[9:0]]), c);
    check(armed == !finalZero, "R11 armed after service", int'(armed), int'(!finalZero));
    check(irq == (irqBefore || (finalZero && irqEn)), "R11 irq after service",
          int'(irq), int'(irqBefore || (finalZero && irqEn)));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit sawReq;
    unusedSeed = $urandom(32'd1234);
    for (int i = 0; i < 1024; i++) mem[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(!busReq && !memRe && !memWe, "R2 idle after reset", int'(busReq), 0);
    check(!armed && !irq, "R11 flags after reset", int'(armed) + int'(irq), 0);
    check(!xferAck && !xferEnd, "R5 strobes after reset", int'(xferAck), 0);

    // R1: disarmed channel ignores requests
    sawReq = 0; dreq = 1'b1;
    repeat (40) begin @(negedge clk); if (busReq) sawReq = 1; end
    dreq = 1'b0;
    check(!sawReq, "R1 request while disarmed", int'(sawReq), 0);
    pulseArm();
    check(armed, "R1 armSet arms", int'(armed), 1);

    // R7 burst, both stepping up, request dropped after first transfer
    srcModeR = 2'b01; dstModeR = 2'b01; irqEn = 1'b1;
    setDesc(16'd900, 16'd3, 16'd200, 16'd500);
    runService(1'b1, 1);

    // R11 sticky interrupt, then clear
    repeat (20) @(negedge clk);
    check(irq, "R11 irq sticky", int'(irq), 1);
    pulseClr();
    check(!irq, "R11 irq cleared", int'(irq), 0);

    // R6 continuous, source stepping down, destination fixed, stopped after 2
    irqEn = 1'b0; srcModeR = 2'b10; dstModeR = 2'b00;
    setDesc(16'd910, 16'd6, 16'd300, 16'd520);
    pulseArm();
    runService(1'b0, 2);
    // R11 resume from written-back descriptor
    runService(1'b0, 10);

    // R12 zero-count descriptor
    irqEn = 1'b1; srcModeR = 2'b01; dstModeR = 2'b10;
    setDesc(16'd920, 16'd0, 16'd210, 16'd540);
    pulseArm();
    runService(1'b1, 1);
    pulseClr();

    // R8 mode 11 treated as fixed
    srcModeR = 2'b11; dstModeR = 2'b11;
    setDesc(16'd930, 16'd2, 16'd220, 16'd560);
    pulseArm();
    runService(1'b1, 1);
    check(mem[560] == {8'h00, mem[220][7:0]}, "R8 fixed destination holds last byte",
          int'(mem[560]), int'({8'h00, mem[220][7:0]}));
    pulseClr();

    // random services
    for (int t = 0; t < 20; t++) begin
      logic [1:0] sm, dm;
      sm = 2'($urandom); dm = 2'($urandom);
      srcModeR = sm; dstModeR = dm;
      irqEn = 1'($urandom);
      setDesc(16'(940 + (t % 4) * 4), 16'($urandom % 11),
              16'(230 + $urandom % 40), 16'(580 + $urandom % 40));
      pulseClr();
      pulseArm();
      runService(1'($urandom), 1 + int'($urandom % 12));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule